// File: doc/BRIEF.md
# Burst Enable Conditioner

This block turns an asynchronous, active-low burst enable pin into the clean control signals that switch a set of output current channels on and off together. Two programmable current channels and one bias channel share the one enable: all of them follow it at the same time. When the burst enable is inactive, the bias current is not cut. It is routed to a ballast load instead, so the analog stages stay biased for the next burst.

The pin is always captured by one synchronizing flop. In filtered mode a persistence filter follows that flop. The filter only accepts a new level once that level has been sampled for `FILT_LEN` consecutive clocks, which removes short noise pulses. In fast mode, set by a static configuration bit, the filter is skipped and the outputs follow the synchronizer directly, which gives the lowest latency. The filter keeps tracking the pin in both modes.

After reset every output is low, the ballast select included. The ballast path is first used after the conditioned enable has been active at least once.

Top module: `burst_enable_cond`

## Requirements
- R1: While reset is asserted, and after it until the first time the conditioned enable is active, `chan_en`, `bias_en` and `ballast_sel` are all 0.
- R2: In fast mode (`fast_mode`=1), a change of `burst_en_n` made between two rising edges appears at the outputs right after the next rising edge (one clock of latency).
- R3: In filtered mode (`fast_mode`=0), a new level of `burst_en_n` held for at least `FILT_LEN` clocks (default 4) appears at the outputs after the `FILT_LEN`+1-th rising edge following the change.
- R4: In filtered mode, a level of `burst_en_n` held for fewer than `FILT_LEN` clocks, in either direction, causes no change at any output.
- R5: Every bit of `chan_en` equals `bias_en` at all times. The channels and the bias are switched together.
- R6: `bias_en` and `ballast_sel` are never both 1. Once the conditioned enable has been active, exactly one of them is 1.
- R7: `burst_en_n` is active low: 0 requests current and 1 withdraws it. When it is withdrawn after a burst, `ballast_sel` becomes 1 in the same cycle that `bias_en` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | Static configuration: 1 bypasses the persistence filter |
| burst_en_n | input | 1 | Asynchronous active-low burst enable pin |
| chan_en | output | NUM_CH | Enable for each programmable current channel |
| bias_en | output | 1 | Bias current routed to the laser output |
| ballast_sel | output | 1 | Bias current routed to the ballast load |

## Verification
A wrong filter count shows up at the outputs as an edge one clock early or late. It can also show up as a pulse of exactly `FILT_LEN`-1 or `FILT_LEN` clocks being passed or swallowed wrongly. The bench sweeps pulse widths around that limit in both directions so that such an error is caught within a few clocks of the pulse. A damaged arming flag or steering term shows within one cycle, as `ballast_sel` rising before the first burst or agreeing with `bias_en`. A mis-wired channel replica shows on the first edge of any burst.

// File: rtl/bge_pkg.sv
package bge_pkg;
  typedef enum logic {
    PATH_FILTERED = 1'b0,
    PATH_FAST     = 1'b1
  } path_e;
endpackage

// File: rtl/bge_sync.sv
module bge_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bge_filter.sv
module bge_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b0;
      run <= '0;
    end else if (d == q) begin
      run <= '0;
    end else if (run == LAST) begin
      q   <= d;
      run <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/bge_steer.sv
module bge_steer #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  output logic [NUM_CH-1:0] chan_en,
  output logic              bias_en,
  output logic              ballast_sel
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (active) armed <= 1'b1;
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign chan_en[c] = active;
    end
  endgenerate

  assign bias_en     = active;
  assign ballast_sel = armed & ~active;
endmodule

// File: rtl/burst_enable_cond.sv
module burst_enable_cond
  import bge_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_mode,
  input  logic              burst_en_n,
  output logic [NUM_CH-1:0] chan_en,
  output logic              bias_en,
  output logic              ballast_sel
);
  logic  synced;
  logic  filtered;
  logic  active;
  path_e path;

  bge_sync #(.STAGES(1)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (~burst_en_n),
    .q    (synced)
  );

  bge_filter #(.LEN(FILT_LEN)) i_filter (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (synced),
    .q    (filtered)
  );

  assign path   = fast_mode ? PATH_FAST : PATH_FILTERED;
  assign active = (path == PATH_FAST) ? synced : filtered;

  bge_steer #(.NUM_CH(NUM_CH)) i_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .chan_en    (chan_en),
    .bias_en    (bias_en),
    .ballast_sel(ballast_sel)
  );
endmodule

// File: rtl/bge_checker.sv
module bge_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fast_mode,
  input logic              burst_en_n,
  input logic [NUM_CH-1:0] chan_en,
  input logic              bias_en,
  input logic              ballast_sel
);
  logic       seen;
  logic [1:0] up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      up   <= '0;
    end else begin
      if (bias_en) seen <= 1'b1;
      if (up != 2'd3) up <= up + 1'b1;
    end
  end

  p_chan_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en == {NUM_CH{bias_en}});

  p_never_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bias_en && ballast_sel));

  p_one_hot_after_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (bias_en ^ ballast_sel));

  p_quiet_before_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && !bias_en) |-> !ballast_sel);

  p_fast_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up == 2'd3 && fast_mode && $past(fast_mode)) |-> (bias_en == !$past(burst_en_n)));

  p_filtered_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up == 2'd3 && !fast_mode && $past(!fast_mode) && (bias_en != $past(bias_en)))
      |-> (bias_en == !$past(burst_en_n, 2)));
endmodule

bind burst_enable_cond bge_checker #(.NUM_CH(NUM_CH)) i_bge_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .fast_mode  (fast_mode),
  .burst_en_n (burst_en_n),
  .chan_en    (chan_en),
  .bias_en    (bias_en),
  .ballast_sel(ballast_sel)
);

// File: tb/test_burst_enable_cond.sv
module test_burst_enable_cond;
  localparam int NUM_CH   = 2;
  localparam int FILT_LEN = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fast_mode = 1'b0;
  logic              burst_en_n = 1'b1;
  logic [NUM_CH-1:0] chan_en;
  logic              bias_en;
  logic              ballast_sel;

  int  tests = 0;
  int  fails = 0;
  bit  armed_exp = 1'b0;

  always #2 clk = ~clk;

  burst_enable_cond #(.NUM_CH(NUM_CH), .FILT_LEN(FILT_LEN)) i_burst_enable_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast_mode  (fast_mode),
    .burst_en_n (burst_en_n),
    .chan_en    (chan_en),
    .bias_en    (bias_en),
    .ballast_sel(ballast_sel)
  );

  task automatic check_outs(input bit act, input string tag);
    logic [NUM_CH-1:0] ch_exp;
    bit bal_exp;
    if (act) armed_exp = 1'b1;
    ch_exp  = act ? '1 : '0;
    bal_exp = armed_exp && !act;
    tests++;
    if (bias_en !== act || chan_en !== ch_exp || ballast_sel !== bal_exp) begin
      fails++;
      $display("FAIL %s: bias=%b chan=%b ballast=%b expected bias=%b chan=%b ballast=%b",
               tag, bias_en, chan_en, ballast_sel, act, ch_exp, bal_exp);
    end
  endtask

  // Settle to a steady level (active when lvl=1) and check it.
  task automatic settle(input bit lvl);
    @(negedge clk);
    burst_en_n = ~lvl;
    repeat (FILT_LEN + 4) @(negedge clk);
    check_outs(lvl, "R7 steady level");
  endtask

  // Pulse away from the base level for w clocks, check every cycle.
  task automatic pulse(input bit base, input int w);
    bit fast = fast_mode;
    bit nw;
    @(negedge clk);
    burst_en_n = base;  // active-low: opposite of base activity
    for (int j = 1; j <= w + FILT_LEN + 4; j++) begin
      @(negedge clk);
      if (fast) nw = (j >= 1 && j <= w);
      else      nw = (w >= FILT_LEN) && (j >= FILT_LEN + 1) && (j <= w + FILT_LEN);
      check_outs(nw ? !base : base,
                 fast ? "R2 fast pulse" : (w < FILT_LEN ? "R4 short pulse" : "R3 filtered pulse"));
      if (j == w) burst_en_n = ~base;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    burst_en_n = 1'b0;
    repeat (3) @(negedge clk);
    check_outs(1'b0, "R1 in reset");
    burst_en_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_outs(1'b0, "R1 after reset");
    // Short bursts before arming: ballast must stay off (R1).
    for (int w = 1; w < FILT_LEN; w++) pulse(1'b0, w);
    // Filtered mode sweep, both directions.
    for (int base = 0; base < 2; base++) begin
      settle(base[0]);
      for (int w = 1; w <= FILT_LEN + 3; w++) pulse(base[0], w);
    end
    // Fast mode sweep.
    @(negedge clk);
    fast_mode = 1'b1;
    for (int base = 0; base < 2; base++) begin
      settle(base[0]);
      for (int w = 1; w <= FILT_LEN + 3; w++) pulse(base[0], w);
    end
    // Back to filtered: steady state consistent (R7 withdraw routes to ballast).
    @(negedge clk);
    fast_mode = 1'b0;
    settle(1'b1);
    settle(1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule